// File: doc/BRIEF.md
# Boundary-Scan Instruction and Data-Register Unit

This block is the test-port controller of a synchronous memory device. It walks the standard sixteen-state test-access state machine on TCK and holds a 3-bit instruction register. Behind the instruction register it holds a 32-bit identification register, a one-bit bypass register and a short boundary register that covers a parameterised ring of input and output pins. It also drives the serial TDO output together with its enable.

The block sits between the device core and the pads. In normal operation, core data and the core output enable pass through to the pads unchanged. Under the external-test instruction, the pads take their values from the boundary register. The switch happens only at the first rising edge of the device clock after the instruction takes effect, not when the instruction is updated. Under the sample-and-float instruction, the pads are released to high impedance at once. Reserved instruction codes select the bypass register and leave the pads alone.

Top module: `bscan_ctrl`

## Requirements
- R1: The state machine follows the standard TMS transition graph on rising TCK. Five consecutive rising TCK edges with TMS high reach Test-Logic-Reset from any state.
- R2: trst_n low forces Test-Logic-Reset and the identification instruction at once, without a TCK edge.
- R3: After reset, and on every pass through Test-Logic-Reset, the active instruction is identification (code 001). A Shift-DR that follows then reads out the identification value.
- R4: Capture-IR loads 001 into the instruction shift register. It shifts LSB first, and the new instruction takes effect on the falling TCK edge in Update-IR.
- R5: The codes decode as follows. 000 is external test, 001 is identification and 010 is sample-and-float; these three select the boundary register, the ID register and the boundary register respectively. 100 is sample/preload (boundary register). 111 is bypass. The reserved codes 011, 101 and 110 select the bypass register and change no pad.
- R6: Capture-DR under identification loads the 32-bit ID_VALUE parameter with bit 0 forced to 1. It shifts out LSB first.
- R7: The bypass register captures 0 and delays TDI by one TCK cycle.
- R8: Capture-DR under a boundary instruction loads the boundary register as follows. Bits [N_IN-1:0] take pin_in and the next N_OUT bits take pad_out. The top bit takes the SPARE_VAL default. Update-DR copies the output cells to a hold register on falling TCK.
- R9: Under sample-and-float, pad_oe is 0 from the Update-IR falling edge onwards.
- R10: Under external test, pad_out and pad_oe keep their previous source until a rising dev_clk edge. From that edge on, pad_out equals the held output cells and pad_oe is 1. Further dev_clk edges change nothing.
- R11: TDO changes on falling TCK. tdo_en is high only while the state is Shift-IR or Shift-DR.
- R12: With any instruction other than external test and sample-and-float, pad_out equals core_out and pad_oe equals core_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out |
| tdo_en | output | 1 | TDO drive enable |
| dev_clk | input | 1 | Main device clock |
| pin_in | input | N_IN | Functional input pin values |
| core_out | input | N_OUT | Output data from the device core |
| core_oe | input | 1 | Output enable from the device core |
| pad_out | output | N_OUT | Data to the output pads |
| pad_oe | output | 1 | Output pad enable |

## Verification
The assertions check the following on every TCK cycle: the five-TMS-high return to reset, the capture values of the instruction, ID and bypass registers, the identification instruction while in reset, the high-impedance override and the TDO enable window. On every device clock edge they check that external test arms the pad hold. Only the bench scenarios can show end-to-end results. These include the full serial readout for each of the eight codes, the fact that the pads wait for a device-clock edge under external test and then keep their value, the preload path into the pads, and the effect of an asynchronous reset in mid-sequence.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef enum logic [3:0] {
    ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR,
    ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {SEL_BSR, SEL_ID, SEL_BYP} dr_sel_e;

  localparam int IR_W = 3;
  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPZ   = 3'b010;
  localparam logic [IR_W-1:0] OP_PRELOAD = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    case (s)
      ST_TLR:    return m ? ST_TLR    : ST_RTI;
      ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
      default:   return m ? ST_SEL_DR : ST_RTI;
    endcase
  endfunction

  function automatic dr_sel_e dr_decode(input logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST, OP_SAMPZ, OP_PRELOAD: return SEL_BSR;
      OP_IDCODE:                       return SEL_ID;
      default:                         return SEL_BYP;
    endcase
  endfunction
endpackage

// File: rtl/bscan_fsm.sv
module bscan_fsm
  import bscan_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_TLR;
    else         state <= tap_next(state, tms);
  end

  logic [2:0] tms_run;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)            tms_run <= '0;
    else if (!tms)          tms_run <= '0;
    else if (tms_run != 3'd7) tms_run <= tms_run + 3'd1;
  end

  assert_five_tms_tlr_R1: assert property (@(posedge tck) disable iff (!trst_n)
    (tms_run >= 3'd5) |-> (state == ST_TLR));
endmodule

// File: rtl/bscan_ir.sv
module bscan_ir
  import bscan_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir_sr,
  output logic [IR_W-1:0] cur_op
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                 ir_sr <= IR_CAPTURE;
    else if (state == ST_CAP_IR) ir_sr <= IR_CAPTURE;
    else if (state == ST_SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                 cur_op <= OP_IDCODE;
    else if (state == ST_TLR)    cur_op <= OP_IDCODE;
    else if (state == ST_UPD_IR) cur_op <= ir_sr;
  end

  assert_ir_capture_R4: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_IR) |=> (ir_sr == IR_CAPTURE));
  assert_idcode_in_reset_R3: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR) |=> (cur_op == OP_IDCODE));
endmodule

// File: rtl/bscan_dr.sv
module bscan_dr
  import bscan_pkg::*;
#(
  parameter int          N_IN      = 4,
  parameter int          N_OUT     = 4,
  parameter logic [31:0] ID_VALUE  = 32'h0B5E_C1A3,
  parameter logic        SPARE_VAL = 1'b0
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tdi,
  input  tap_state_e       state,
  input  dr_sel_e          sel,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] pad_now,
  output logic             dr_lsb,
  output logic [N_OUT-1:0] hold_out
);
  localparam int BSR_LEN = N_IN + N_OUT + 1;
  localparam logic [31:0] ID_FIXED = {ID_VALUE[31:1], 1'b1};

  logic [BSR_LEN-1:0] bsr_sr;
  logic [31:0]        id_sr;
  logic               byp_q;

  wire cap_ev = (state == ST_CAP_DR);
  wire sh_ev  = (state == ST_SH_DR);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      bsr_sr <= '0;
      id_sr  <= ID_FIXED;
      byp_q  <= 1'b0;
    end else begin
      if (sel == SEL_BSR) begin
        if (cap_ev)     bsr_sr <= {SPARE_VAL, pad_now, pin_in};
        else if (sh_ev) bsr_sr <= {tdi, bsr_sr[BSR_LEN-1:1]};
      end
      if (sel == SEL_ID) begin
        if (cap_ev)     id_sr <= ID_FIXED;
        else if (sh_ev) id_sr <= {tdi, id_sr[31:1]};
      end
      if (sel == SEL_BYP) begin
        if (cap_ev)     byp_q <= 1'b0;
        else if (sh_ev) byp_q <= tdi;
      end
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) hold_out <= '0;
    else if (state == ST_UPD_DR && sel == SEL_BSR) hold_out <= bsr_sr[N_IN +: N_OUT];
  end

  always_comb begin
    case (sel)
      SEL_BSR: dr_lsb = bsr_sr[0];
      SEL_ID:  dr_lsb = id_sr[0];
      default: dr_lsb = byp_q;
    endcase
  end

  assert_id_lsb_one_R6: assert property (@(posedge tck) disable iff (!trst_n)
    (cap_ev && sel == SEL_ID) |=> (id_sr[0] == 1'b1));
  assert_bypass_zero_R7: assert property (@(posedge tck) disable iff (!trst_n)
    (cap_ev && sel == SEL_BYP) |=> (byp_q == 1'b0));
endmodule

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
  import bscan_pkg::*;
#(
  parameter int          N_IN      = 4,
  parameter int          N_OUT     = 4,
  parameter logic [31:0] ID_VALUE  = 32'h0B5E_C1A3,
  parameter logic        SPARE_VAL = 1'b0
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_en,
  input  logic             dev_clk,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic             core_oe,
  output logic [N_OUT-1:0] pad_out,
  output logic             pad_oe
);
  tap_state_e       state;
  logic [IR_W-1:0]  ir_sr, cur_op;
  dr_sel_e          sel;
  logic             dr_lsb;
  logic [N_OUT-1:0] hold_out, ext_data;
  logic             ext_act;

  bscan_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

  bscan_ir u_ir (.tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state),
                 .ir_sr(ir_sr), .cur_op(cur_op));

  assign sel = dr_decode(cur_op);

  bscan_dr #(.N_IN(N_IN), .N_OUT(N_OUT), .ID_VALUE(ID_VALUE), .SPARE_VAL(SPARE_VAL)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state), .sel(sel),
    .pin_in(pin_in), .pad_now(pad_out), .dr_lsb(dr_lsb), .hold_out(hold_out));

  wire sz_mode   = (cur_op == OP_SAMPZ);
  wire shift_any = (state == ST_SH_IR) || (state == ST_SH_DR);

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= shift_any;
      if (state == ST_SH_IR)      tdo <= ir_sr[0];
      else if (state == ST_SH_DR) tdo <= dr_lsb;
    end
  end

  // Device-clock side: pads adopt boundary contents only on a dev_clk edge.
  always_ff @(posedge dev_clk or negedge trst_n) begin
    if (!trst_n) begin
      ext_act  <= 1'b0;
      ext_data <= '0;
    end else begin
      ext_act  <= (cur_op == OP_EXTEST);
      ext_data <= hold_out;
    end
  end

  assign pad_out = ext_act ? ext_data : core_out;
  assign pad_oe  = sz_mode ? 1'b0 : (ext_act ? 1'b1 : core_oe);

  assert_float_forces_oe_R9: assert property (@(posedge tck) disable iff (!trst_n)
    (cur_op == OP_SAMPZ) |-> !pad_oe);
  assert_tdo_window_R11: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en |-> shift_any);
  assert_extest_arms_R10: assert property (@(posedge dev_clk) disable iff (!trst_n)
    (cur_op == OP_EXTEST) |=> ext_act);
endmodule

// File: tb/bscan_ctrl_tb_top.sv
module bscan_ctrl_tb_top;
  localparam int NI = 4, NO = 4, BL = NI + NO + 1;
  localparam logic [31:0] IDV = 32'h0B5E_C1A3;
  localparam logic [63:0] PAT = 64'hC3A5_96F0_0F69_5A3C;
  // {code[2:0], kind[1:0]}: kind 0 boundary, 1 id, 2 bypass
  localparam logic [4:0] TBL [8] = '{
    {3'b000, 2'd0}, {3'b001, 2'd1}, {3'b010, 2'd0}, {3'b011, 2'd2},
    {3'b100, 2'd0}, {3'b101, 2'd2}, {3'b110, 2'd2}, {3'b111, 2'd2}};

  logic tck = 0, trst_n = 0, tms = 1, tdi = 0, dev_clk = 0, core_oe = 1;
  logic [NI-1:0] pin_in = 4'h5;
  logic [NO-1:0] core_out = 4'hA;
  logic tdo, tdo_en, pad_oe;
  logic [NO-1:0] pad_out;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 tck = ~tck;

  bscan_ctrl #(.N_IN(NI), .N_OUT(NO), .ID_VALUE(IDV)) dut_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .dev_clk(dev_clk), .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
    .pad_out(pad_out), .pad_oe(pad_oe));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o, output logic e);
    @(negedge tck); #2;
    o = tdo; e = tdo_en; tms = m; tdi = d;
    @(posedge tck); #1;
  endtask

  task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
    logic o, e;
    step(0, 0, o, e); step(1, 0, o, e); step(1, 0, o, e);
    step(0, 0, o, e); step(0, 0, o, e);
    for (int i = 0; i < 3; i++) step(i == 2, code[i], cap[i], e);
    step(1, 0, o, e); step(0, 0, o, e);
  endtask

  task automatic shift_dr(input int n, input logic [63:0] pat, output logic [63:0] got, output bit en_all);
    logic o, e;
    got = '0; en_all = 1;
    step(0, 0, o, e); step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, pat[i], got[i], e);
      en_all &= e;
    end
    step(1, 0, o, e); step(0, 0, o, e);
  endtask

  task automatic dev_pulse();
    dev_clk = 1; #3; dev_clk = 0; #3;
  endtask

  function automatic logic [31:0] expect_dr(input logic [1:0] kind, input logic [BL-1:0] cap);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      if (kind == 2'd1)      r[i] = (i == 0) ? 1'b1 : IDV[i];
      else if (kind == 2'd2) r[i] = (i == 0) ? 1'b0 : PAT[i-1];
      else                   r[i] = (i < BL) ? cap[i] : PAT[i-BL];
    end
    return r;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [2:0] ircap;
    logic [63:0] got;
    bit en;
    logic [8:0] pre;
    #23;
    // Reset state: R11, R12
    chk(tdo_en == 0, "R11 tdo_en idle after reset", 64'(tdo_en), 0);
    chk(pad_out == core_out && pad_oe == core_oe, "R12 pass-through at reset", 64'({pad_oe, pad_out}), 64'({core_oe, core_out}));
    trst_n = 1;
    // R3 identification by default, R6 id value
    shift_dr(32, PAT, got, en);
    chk(got[31:0] == {IDV[31:1], 1'b1}, "R3 R6 default readout", got, 64'({IDV[31:1], 1'b1}));
    chk(en && tdo_en == 0, "R11 tdo_en only in shift", 64'({en, tdo_en}), 64'b10);

    // Table walk: R4 R5 R6 R7 R8 R9 R12
    foreach (TBL[k]) begin
      logic [2:0] code;
      logic [1:0] kind;
      logic [31:0] exp;
      code = TBL[k][4:2]; kind = TBL[k][1:0];
      load_ir(code, ircap);
      chk(ircap == 3'b001, "R4 capture-IR pattern", 64'(ircap), 64'd1);
      chk(pad_oe == ((code == 3'b010) ? 1'b0 : core_oe), "R9 R12 pad_oe per code", 64'(pad_oe), 64'((code == 3'b010) ? 1'b0 : core_oe));
      chk(pad_out == core_out, "R12 R5 pad_out untouched", 64'(pad_out), 64'(core_out));
      exp = expect_dr(kind, {1'b0, core_out, pin_in});
      shift_dr(32, PAT, got, en);
      chk(got[31:0] == exp, "R5 R7 R8 DR readout by code", got, 64'(exp));
    end

    // External test: R10
    pre = 9'b0_1101_0011;
    load_ir(3'b100, ircap);
    shift_dr(BL, 64'(pre), got, en);
    load_ir(3'b000, ircap);
    chk(pad_out == core_out && pad_oe == core_oe, "R10 no change before dev_clk", 64'({pad_oe, pad_out}), 64'({core_oe, core_out}));
    dev_pulse();
    chk(pad_out == pre[7:4] && pad_oe == 1, "R10 pads after dev_clk", 64'({pad_oe, pad_out}), 64'({1'b1, pre[7:4]}));
    core_out = 4'h3; core_oe = 0;
    dev_pulse(); dev_pulse();
    chk(pad_out == pre[7:4] && pad_oe == 1, "R10 extra dev_clk harmless", 64'({pad_oe, pad_out}), 64'({1'b1, pre[7:4]}));
    pin_in = 4'h9;
    shift_dr(BL, 64'(pre), got, en);
    chk(got[8:0] == {1'b0, pre[7:4], 4'h9}, "R8 extest capture", got, 64'({1'b0, pre[7:4], 4'h9}));
    load_ir(3'b001, ircap);
    dev_pulse();
    chk(pad_out == core_out && pad_oe == core_oe, "R12 release after extest", 64'({pad_oe, pad_out}), 64'({core_oe, core_out}));

    // R1: five TMS-high from inside Shift-DR
    load_ir(3'b111, ircap);
    begin
      logic o, e;
      step(0, 0, o, e); step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
      for (int i = 0; i < 5; i++) step(1, 0, o, e);
    end
    shift_dr(32, PAT, got, en);
    chk(got[31:0] == {IDV[31:1], 1'b1}, "R1 R3 five TMS-high reset", got, 64'({IDV[31:1], 1'b1}));

    // R2: asynchronous reset mid-sequence
    load_ir(3'b111, ircap);
    #3 trst_n = 0; #4 trst_n = 1;
    shift_dr(32, PAT, got, en);
    chk(got[31:0] == {IDV[31:1], 1'b1}, "R2 trst restores identification", got, 64'({IDV[31:1], 1'b1}));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule